// File: doc/BRIEF.md
# Complex-Sample Digital Phase-Locked Loop

This block tracks the phase of a complex baseband signal one sample at a time. Each I/Q pair arrives on a ready/valid stream. On acceptance the block first steps its own phase by the current increment, then drives a cosine/sine oscillator output from the stepped phase. It measures the angle of the incoming sample with a vectoring CORDIC. The raw, unwrapped difference between that angle and the oscillator phase is the phase error. This error drives a loop filter, and the filter yields the next phase increment. That increment leaves on a valid-only output stream, one word per processed sample.

Two loop filters are selectable at run time. One is a first-order smoother with a weight `alpha`. The other is a second-order recursion whose feedback part is a fixed double integrator. A host sets the filter type, `alpha` and the three feed-forward taps through a small write port, and only while no sample is in flight. Writing the type register also clears all loop state. Phase is a signed 16-bit fraction of pi, so the wrap into [-pi, pi) is ordinary two's-complement overflow. Increments, errors and coefficients are signed Q8.16 values in units of pi.

Top module: `cplx_pll`

## Requirements
- R1: Phase `p` is 16-bit signed with a weight of pi/32768. On each accepted sample, `p` becomes `p + inc[16:1]` modulo 2^16, using the increment held before that sample. At no other time does `p` change, except for the clear in R10.
- R2: Two cycles after acceptance, `osc_cos` and `osc_sin` equal 32767·cos(p·pi/32768) and 32767·sin(p·pi/32768) to within ±300, where `p` is the stepped phase. They are already valid when the increment for that sample appears.
- R3: The input angle is atan2(in_i, in_q), with `in_i` as the first argument. It is quantised to a 16-bit fraction of pi. The error `e` is (angle − p) as an unwrapped 17-bit difference, shifted left by one into Q8.16 units of pi.
- R4: With type code 1, the new increment is `inc + floor(alpha·(e − inc)/2^16)`. It must lie within ±64 LSB of that value computed with an ideal arctangent.
- R5: With type code 2, the new increment is `floor((b0·e[n] + b1·e[n−1] + b2·e[n−2])/2^16) + 2·y[n−1] − y[n−2]`. It must lie within ±64 LSB of the ideal-arctangent value.
- R6: With any other type code, a sample still steps the phase and the oscillator. It produces no `out_valid`, and `out_inc` keeps its value.
- R7: Filter results outside the signed 24-bit range saturate to 8388607 or −8388608.
- R8: `in_ready` is low from the cycle after acceptance until the result cycle. Each sample processed with code 1 or 2 gives exactly one single-cycle `out_valid` pulse.
- R9: Writes use `cfg_sel` values 0 = type (`cfg_data[2:0]`), 1 = alpha, 2 = b0, 3 = b1 and 4 = b2. A write made while a sample is in flight is dropped. `in_ready` is low while `cfg_we` is high.
- R10: Reset sets type 1, alpha 655 (about 0.01) and all b taps to 0. A type write clears the phase, the increment and the filter history, so `out_inc` reads 0 on the next cycle. Reset clears all of these too. After reset `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_i | input | 16 | In-phase component, signed |
| in_q | input | 16 | Quadrature component, signed |
| out_valid | output | 1 | One-cycle pulse: new increment |
| out_inc | output | 24 | Phase increment, Q8.16 units of pi |
| osc_cos | output | 16 | Oscillator cosine, signed |
| osc_sin | output | 16 | Oscillator sine, signed |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_data | input | 24 | Configuration write data |

## Verification
The bench applies samples in every quadrant. This catches a detector that swaps its two arctangent arguments or mishandles the left half-plane, since either would give errors of the wrong sign or an offset of pi. It tracks the phase from the observed increments, which exposes a design that applies the new increment before the oscillator is updated, or that wraps the error. A wrong sign on the fixed double-integrator feedback would make the second-order results drift off the model within a few samples. A large alpha drives the result past full scale, where a missing clamp would wrap to a positive number. Further tests write the configuration in mid-sample, use an unknown type code and re-write the type. These catch a block that corrupts its coefficients, emits a spurious result, or keeps stale history.

// File: rtl/cpll_pkg.sv
package cpll_pkg;
  localparam int PH_W   = 16;
  localparam int ZEXT   = 2;
  localparam int Z_W    = PH_W + ZEXT + 2;
  localparam int CF_W   = 24;
  localparam int FRAC_W = 16;
  localparam int TYPE_W = 3;
  localparam int SEL_W  = 3;

  localparam logic [SEL_W-1:0] SEL_TYPE  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_ALPHA = 3'd1;
  localparam logic [SEL_W-1:0] SEL_B0    = 3'd2;

  localparam logic [TYPE_W-1:0] LOOP_FIRST  = 3'd1;
  localparam logic [TYPE_W-1:0] LOOP_SECOND = 3'd2;

  localparam logic signed [CF_W-1:0] ALPHA_RST = 24'sd655;

  typedef enum logic {ST_IDLE, ST_CORD} pll_state_e;

  // arctan(2^-i) in units of pi * 2^-(PH_W+ZEXT-1)
  function automatic logic signed [Z_W-1:0] atan_step(input int i);
    case (i)
      0:  return 20'sd32768;
      1:  return 20'sd19344;
      2:  return 20'sd10221;
      3:  return 20'sd5188;
      4:  return 20'sd2604;
      5:  return 20'sd1303;
      6:  return 20'sd652;
      7:  return 20'sd326;
      8:  return 20'sd163;
      9:  return 20'sd81;
      10: return 20'sd41;
      11: return 20'sd20;
      12: return 20'sd10;
      13: return 20'sd5;
      14: return 20'sd3;
      15: return 20'sd1;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cpll_sine_rom.sv
module cpll_sine_rom #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic [ADDR_W-1:0]        addr_a,
  input  logic [ADDR_W-1:0]        addr_b,
  output logic signed [DATA_W-1:0] data_a,
  output logic signed [DATA_W-1:0] data_b
);
  localparam int  DEPTH = 1 << ADDR_W;
  localparam real AMP   = (2.0 ** (DATA_W - 1)) - 1.0;
  localparam real PI_R  = 3.14159265358979;

  logic signed [DATA_W-1:0] rom [DEPTH];

  // quarter wave sampled at half-step offsets
  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      rom[k] = DATA_W'($rtoi(AMP * $sin((real'(k) + 0.5) * PI_R / (2.0 * DEPTH)) + 0.5));
    end
  end

  always_ff @(posedge clk) begin
    data_a <= rom[addr_a];
    data_b <= rom[addr_b];
  end
endmodule

// File: rtl/cpll_cordic_atan.sv
module cpll_cordic_atan
  import cpll_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ITER   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic signed [DATA_W-1:0] x_in,
  input  logic signed [DATA_W-1:0] y_in,
  output logic                    done,
  output logic signed [PH_W-1:0]  angle
);
  localparam int XY_W = DATA_W + 4;
  localparam int IT_W = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic signed [Z_W-1:0] PI_Z = Z_W'(1 << (PH_W + ZEXT - 1));

  logic signed [XY_W-1:0] x_q, y_q, xs, ys;
  logic signed [Z_W-1:0]  z_q;
  logic [IT_W-1:0]        it_q;
  logic                   run_q;

  assign xs = x_q >>> it_q;
  assign ys = y_q >>> it_q;
  assign angle = PH_W'((z_q + Z_W'(2)) >>> ZEXT);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0; y_q <= '0; z_q <= '0; it_q <= '0;
      run_q <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        it_q  <= '0;
        run_q <= 1'b1;
        if (x_in < 0) begin
          x_q <= -XY_W'(x_in);
          y_q <= -XY_W'(y_in);
          z_q <= (y_in >= 0) ? PI_Z : -PI_Z;
        end else begin
          x_q <= XY_W'(x_in);
          y_q <= XY_W'(y_in);
          z_q <= '0;
        end
      end else if (run_q) begin
        if (y_q >= 0) begin
          x_q <= x_q + ys;
          y_q <= y_q - xs;
          z_q <= z_q + atan_step(int'(it_q));
        end else begin
          x_q <= x_q - ys;
          y_q <= y_q + xs;
          z_q <= z_q - atan_step(int'(it_q));
        end
        if (it_q == IT_W'(ITER - 1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end else begin
          it_q <= it_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cpll_loop_filter.sv
module cpll_loop_filter
  import cpll_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    fire,
  input  logic [TYPE_W-1:0]       mode,
  input  logic signed [CF_W-1:0]  err,
  input  logic signed [CF_W-1:0]  alpha,
  input  logic signed [CF_W-1:0]  b0,
  input  logic signed [CF_W-1:0]  b1,
  input  logic signed [CF_W-1:0]  b2,
  output logic signed [CF_W-1:0]  inc,
  output logic                    inc_vld
);
  localparam int ACC_W = 2 * CF_W + 4;
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (CF_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

  logic signed [CF_W-1:0]  y2_q, e1_q, e2_q;
  logic signed [ACC_W-1:0] ex, yx, ax, d1, p1, first_v, s2, second_v;

  function automatic logic signed [CF_W-1:0] clamp(input logic signed [ACC_W-1:0] v);
    if (v > MAXV)      return CF_W'(MAXV);
    else if (v < MINV) return CF_W'(MINV);
    else               return CF_W'(v);
  endfunction

  always_comb begin
    ex       = ACC_W'(err);
    yx       = ACC_W'(inc);
    ax       = ACC_W'(alpha);
    d1       = ex - yx;
    p1       = ax * d1;
    first_v  = yx + (p1 >>> FRAC_W);
    s2       = ACC_W'(b0) * ex + ACC_W'(b1) * ACC_W'(e1_q) + ACC_W'(b2) * ACC_W'(e2_q);
    second_v = (s2 >>> FRAC_W) + (yx <<< 1) - ACC_W'(y2_q);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      inc <= '0; y2_q <= '0; e1_q <= '0; e2_q <= '0;
      inc_vld <= 1'b0;
    end else begin
      inc_vld <= 1'b0;
      if (fire) begin
        if (mode == LOOP_FIRST) begin
          inc     <= clamp(first_v);
          inc_vld <= 1'b1;
        end else if (mode == LOOP_SECOND) begin
          inc     <= clamp(second_v);
          y2_q    <= inc;
          e2_q    <= e1_q;
          e1_q    <= err;
          inc_vld <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cplx_pll.sv
module cplx_pll
  import cpll_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ROM_AW      = 8,
  parameter int CORDIC_ITER = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  output logic                    out_valid,
  output logic signed [CF_W-1:0]  out_inc,
  output logic signed [DATA_W-1:0] osc_cos,
  output logic signed [DATA_W-1:0] osc_sin,
  input  logic                    cfg_we,
  input  logic [SEL_W-1:0]        cfg_sel,
  input  logic [CF_W-1:0]         cfg_data
);
  localparam int NTAP = 3;

  pll_state_e              state_q;
  logic                    busy, accept, cfg_ok, type_wr;
  logic [TYPE_W-1:0]       loop_type_q;
  logic signed [CF_W-1:0]  alpha_q;
  logic signed [CF_W-1:0]  b_q [NTAP];
  logic signed [PH_W-1:0]  phase_q;
  logic                    cor_done;
  logic signed [PH_W-1:0]  cor_angle;
  logic signed [PH_W:0]    ediff;
  logic signed [CF_W-1:0]  err;
  logic [ROM_AW+1:0]       rom_idx;
  logic [1:0]              quad_q;
  logic signed [DATA_W-1:0] t_a, t_b;

  assign busy     = (state_q != ST_IDLE);
  assign in_ready = !busy && !cfg_we;
  assign accept   = in_valid && in_ready;
  assign cfg_ok   = cfg_we && !busy;
  assign type_wr  = cfg_ok && (cfg_sel == SEL_TYPE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else if (accept) begin
      state_q <= ST_CORD;
    end else if (cor_done) begin
      state_q <= ST_IDLE;
    end
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      loop_type_q <= LOOP_FIRST;
      alpha_q     <= ALPHA_RST;
    end else if (cfg_ok) begin
      if (cfg_sel == SEL_TYPE)  loop_type_q <= cfg_data[TYPE_W-1:0];
      if (cfg_sel == SEL_ALPHA) alpha_q     <= cfg_data;
    end
  end

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) begin
        b_q[g] <= '0;
      end else if (cfg_ok && (cfg_sel == SEL_B0 + SEL_W'(g))) begin
        b_q[g] <= cfg_data;
      end
    end
  end

  // phase accumulator, wraps by overflow
  always_ff @(posedge clk) begin
    if (rst || type_wr) begin
      phase_q <= '0;
    end else if (accept) begin
      phase_q <= phase_q + out_inc[PH_W:1];
    end
  end

  // oscillator: quarter-wave table with quadrant folding
  assign rom_idx = phase_q[PH_W-1 -: ROM_AW+2];

  cpll_sine_rom #(.ADDR_W(ROM_AW), .DATA_W(DATA_W)) u_rom (
    .clk    (clk),
    .addr_a (rom_idx[ROM_AW-1:0]),
    .addr_b (~rom_idx[ROM_AW-1:0]),
    .data_a (t_a),
    .data_b (t_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      quad_q  <= '0;
      osc_cos <= '0;
      osc_sin <= '0;
    end else begin
      quad_q <= rom_idx[ROM_AW+1:ROM_AW];
      case (quad_q)
        2'd0: begin osc_sin <= t_a;  osc_cos <= t_b;  end
        2'd1: begin osc_sin <= t_b;  osc_cos <= -t_a; end
        2'd2: begin osc_sin <= -t_a; osc_cos <= -t_b; end
        default: begin osc_sin <= -t_b; osc_cos <= t_a; end
      endcase
    end
  end

  // phase detector: atan2(I, Q)
  cpll_cordic_atan #(.DATA_W(DATA_W), .ITER(CORDIC_ITER)) u_cordic (
    .clk   (clk),
    .rst   (rst),
    .start (accept),
    .x_in  (in_q),
    .y_in  (in_i),
    .done  (cor_done),
    .angle (cor_angle)
  );

  assign ediff = (PH_W+1)'(cor_angle) - (PH_W+1)'(phase_q);
  assign err   = CF_W'(ediff) <<< 1;

  cpll_loop_filter u_filt (
    .clk     (clk),
    .rst     (rst),
    .clear   (type_wr),
    .fire    (cor_done),
    .mode    (loop_type_q),
    .err     (err),
    .alpha   (alpha_q),
    .b0      (b_q[0]),
    .b1      (b_q[1]),
    .b2      (b_q[2]),
    .inc     (out_inc),
    .inc_vld (out_valid)
  );
endmodule

// File: rtl/cpll_checker.sv
module cpll_checker
  import cpll_pkg::*;
(
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic signed [CF_W-1:0] out_inc,
  input logic                   cfg_we,
  input logic [SEL_W-1:0]       cfg_sel,
  input logic                   busy,
  input logic [TYPE_W-1:0]      loop_type,
  input logic signed [CF_W-1:0] alpha,
  input logic signed [PH_W-1:0] phase
);
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_known_type_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (loop_type == LOOP_FIRST || loop_type == LOOP_SECOND));

  assert_inc_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(cfg_we && !busy && cfg_sel == SEL_TYPE)) |-> $stable(out_inc));

  assert_cfg_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && busy) |=> $stable(alpha));

  assert_phase_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_valid && in_ready) && !$past(cfg_we && !busy && cfg_sel == SEL_TYPE))
      |-> $stable(phase));
endmodule

bind cplx_pll cpll_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_inc   (out_inc),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .busy      (busy),
  .loop_type (loop_type_q),
  .alpha     (alpha_q),
  .phase     (phase_q)
);

// File: tb/cplx_pll_bench.sv
module cplx_pll_bench;
  localparam real PI = 3.14159265358979;
  localparam int  NV = 8;
  localparam int  VI [NV] = '{20000, -12000, 3000, -20000, 15000, 0, -25000, 10000};
  localparam int  VQ [NV] = '{5000, 18000, -25000, -9000, 15000, 20000, 1000, -10000};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic out_valid;
  logic signed [23:0] out_inc;
  logic signed [15:0] osc_cos, osc_sin;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [23:0] cfg_data = '0;

  int n_chk = 0, n_bad = 0;
  int ph = 0, e1m = 0, e2m = 0;
  longint inc_m = 0, y2m = 0, alpha_m = 655, b0m = 0, b1m = 0, b2m = 0;
  int type_m = 1;

  always #4 clk = ~clk;

  cplx_pll u_cplx_pll (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_inc(out_inc),
    .osc_cos(osc_cos), .osc_sin(osc_sin), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data)
  );

  function automatic int wrap16(input longint v);
    logic signed [15:0] t;
    t = v[15:0];
    return int'(t);
  endfunction

  function automatic longint rnd(input real x);
    if (x >= 0.0) return longint'($rtoi(x + 0.5));
    else return -longint'($rtoi(-x + 0.5));
  endfunction

  function automatic longint sat24(input longint v);
    if (v > 8388607) return 8388607;
    if (v < -8388608) return -8388608;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic near(input string req, input string what, input longint act,
                      input longint exp, input longint tol);
    check((act - exp <= tol) && (exp - act <= tol), req, what, act, exp);
  endtask

  task automatic model_clear();
    ph = 0; inc_m = 0; y2m = 0; e1m = 0; e2m = 0;
  endtask

  task automatic cfg(input logic [2:0] sel, input longint data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = data[23:0];
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      3'd0: begin type_m = int'(data); model_clear(); end
      3'd1: alpha_m = longint'($signed(data[23:0]));
      3'd2: b0m = longint'($signed(data[23:0]));
      3'd3: b1m = longint'($signed(data[23:0]));
      3'd4: b2m = longint'($signed(data[23:0]));
      default: ;
    endcase
  endtask

  task automatic run_sample(input int vi, input int vq, input string req,
                            input longint late_alpha);
    int ang, e;
    longint exp, act;
    bit seen;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_i = 16'(vi); in_q = 16'(vq);
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R8", "in_ready after accept", longint'(in_ready), 0);
    if (late_alpha >= 0) begin
      cfg_we = 1'b1; cfg_sel = 3'd1; cfg_data = late_alpha[23:0];
      @(negedge clk);
      cfg_we = 1'b0;
    end
    ph  = wrap16(ph + (inc_m >>> 1));
    ang = wrap16(rnd($atan2(real'(vi), real'(vq)) / PI * 32768.0));
    e   = (ang - ph) * 2;
    seen = 1'b0;
    if (type_m == 1 || type_m == 2) begin
      for (int c = 0; c < 40; c++) begin
        if (out_valid) begin seen = 1'b1; break; end
        @(negedge clk);
      end
      check(seen, "R8", "result pulse", longint'(seen), 1);
      near("R2", "osc_cos", osc_cos, rnd(32767.0 * $cos(real'(ph) * PI / 32768.0)), 300);
      near("R2", "osc_sin", osc_sin, rnd(32767.0 * $sin(real'(ph) * PI / 32768.0)), 300);
      act = longint'(out_inc);
      if (type_m == 1) begin
        exp = sat24(inc_m + ((alpha_m * (longint'(e) - inc_m)) >>> 16));
      end else begin
        exp = sat24(((b0m * e + b1m * e1m + b2m * e2m) >>> 16) + 2 * inc_m - y2m);
        y2m = inc_m;
        e2m = e1m;
        e1m = e;
      end
      near(req, "out_inc", act, exp, 64);
      inc_m = act;
      @(negedge clk);
      check(out_valid == 1'b0, "R8", "pulse width", longint'(out_valid), 0);
    end else begin
      for (int c = 0; c < 30; c++) begin
        if (out_valid) seen = 1'b1;
        @(negedge clk);
      end
      check(!seen, "R6", "no result for unknown code", longint'(seen), 0);
      check(longint'(out_inc) == inc_m, "R6", "increment held", out_inc, inc_m);
      near("R6", "osc_cos", osc_cos, rnd(32767.0 * $cos(real'(ph) * PI / 32768.0)), 300);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit seen;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(in_ready == 1'b1, "R10", "in_ready after reset", longint'(in_ready), 1);
    check(out_valid == 1'b0, "R10", "out_valid after reset", longint'(out_valid), 0);
    check(out_inc == 0, "R10", "out_inc after reset", out_inc, 0);

    // R10: default alpha, type 1
    run_sample(20000, 5000, "R10", -1);

    // R1 R2 R3 R4: vector table, first-order loop
    cfg(3'd1, 24'h008000);
    for (int v = 0; v < NV; v++) run_sample(VI[v], VQ[v], "R4", -1);

    // R9: write during conversion is dropped
    run_sample(-15000, 20000, "R9", 24'h7FFFFF);
    run_sample(9000, -3000, "R9", -1);

    // R9: cfg_we holds off the input stream
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd1; cfg_data = alpha_m[23:0]; in_valid = 1'b1;
    #1;
    check(in_ready == 1'b0, "R9", "in_ready during cfg write", longint'(in_ready), 0);
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    seen = 1'b0;
    for (int c = 0; c < 30; c++) begin
      if (out_valid) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, "R9", "sample not taken during cfg write", longint'(seen), 0);

    // R10: type write clears state
    cfg(3'd0, 1);
    check(out_inc == 0, "R10", "out_inc after type write", out_inc, 0);
    run_sample(-20000, 7000, "R10", -1);

    // R5: second-order loop
    cfg(3'd0, 2);
    cfg(3'd2, 24'h008000);
    cfg(3'd3, 24'h004000);
    cfg(3'd4, 24'hFFE000);
    for (int v = 0; v < 5; v++) run_sample(VI[v], VQ[v], "R5", -1);

    // R7: saturation
    cfg(3'd0, 1);
    cfg(3'd1, 24'h7FFFFF);
    run_sample(20000, -30000, "R7", -1);
    run_sample(1000, 1000, "R7", -1);
    check(out_inc == -24'sd8388608, "R7", "clamped to minimum", out_inc, -8388608);

    // R6: unknown loop code
    cfg(3'd0, 3);
    for (int v = 0; v < 3; v++) run_sample(VI[v], VQ[v], "R6", -1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule